// File: doc/BRIEF.md
# Histogram-Driven K-Winner Selector

This block picks roughly K winners among a large set of entries. Each entry already holds a small match count, and a histogram gives the number of entries at each count. On a start strobe the block reads the histogram one bin per cycle. It begins at the highest possible count and works downward, adding each bin into a running total. It stops at the first bin where the total reaches K, or at bin zero, and publishes that bin index as the threshold.

It then reads the count memory, 64 counts per word, and marks each entry whose count is strictly above the threshold. The winner vector leaves the block as one 64-bit word per cycle, in increasing word order, each word with a valid strobe. A done pulse comes with the final word. No sorting is done.

Because the comparison is strict, the winner count can fall below K. This is intended behaviour. Both memories are outside the block and return read data one cycle after the address is presented.

Top module: `kwin_select`

## Requirements
- R1: After reset, `thresh` is 0 and `win_valid`, `done`, `hist_ren` and `cnt_ren` are all low.
- R2: A run's histogram reads start at bin 120 (the highest count) and go down by exactly one bin on each consecutive read cycle.
- R3: The scan stops at the first bin where the running total of bin values, counted from bin 120 downward, is at least K (512). That bin index becomes the threshold, even when this leaves fewer than K winners.
- R4: If the running total is still below K when bin 0 is added, the scan stops there and the threshold is 0.
- R5: The running total never wraps. It holds any sum up to 8192 (14 bits) when the histogram is consistent with the counts.
- R6: Bit l of word w is the winner bit of entry w*64+l. That entry's count is read from bits [l*7 +: 7] of count word w. The bit is 1 when the count is strictly greater than the threshold, and 0 otherwise.
- R7: Each run emits exactly 128 words on 128 consecutive cycles, with `win_valid` high and `win_widx` running 0, 1, ..., 127.
- R8: `thresh` changes only when a scan ends. It keeps its value through the winner output and through the next run's scan.
- R9: `done` is high for exactly one cycle, in the same cycle as the valid strobe of word 127.
- R10: A start strobe that arrives while a run is in progress, up to and including its done cycle, is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Begin a run (single-cycle strobe) |
| hist_ren | output | 1 | Histogram read enable |
| hist_raddr | output | 7 | Histogram bin address |
| hist_rdata | input | 14 | Bin population, one cycle after the address |
| cnt_ren | output | 1 | Count memory read enable |
| cnt_raddr | output | 7 | Count word address (64 entries per word) |
| cnt_rdata | input | 448 | 64 packed 7-bit counts, one cycle after the address |
| thresh | output | 7 | Chosen threshold bin |
| win_valid | output | 1 | Winner word valid |
| win_widx | output | 7 | Index of the winner word |
| win_bits | output | 64 | Winner bits, one per entry |
| done | output | 1 | Run complete, aligned with the last word |

## Verification
Two events in the scan can fall in the same cycle: reaching K and reaching the lower bin limit. One pattern puts 511 entries at count 100 and the rest at 0, so the total passes K exactly as bin 0 is added. The expected result is a threshold of 0 with 511 winners. A second pattern zeroes the histogram, so only the lower limit applies. The output side is also covered: done must land on the cycle of word 127 and no other, and a start strobe sent in the middle of output must leave the word stream, the threshold and the idle state after done untouched.

// File: rtl/kws_pkg.sv
package kws_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SCAN = 2'd1,
        ST_EMIT = 2'd2
    } run_state_e;

endpackage

// File: rtl/kws_lane_cmp.sv
module kws_lane_cmp #(
    parameter int CNT_W = 7
) (
    input  logic [CNT_W-1:0] count,
    input  logic [CNT_W-1:0] limit,
    output logic             hit
);

    always_comb begin
        hit = (count > limit);
    end

endmodule

// File: rtl/kws_hist_scan.sv
module kws_hist_scan #(
    parameter int MAX_BIN   = 120,
    parameter int K_WIN     = 512,
    parameter int N_ENTRIES = 8192,
    localparam int BIN_W    = $clog2(MAX_BIN + 1),
    localparam int TOT_W    = $clog2(N_ENTRIES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    output logic             hist_ren,
    output logic [BIN_W-1:0] hist_raddr,
    input  logic [TOT_W-1:0] hist_rdata,
    output logic             fin,
    output logic [BIN_W-1:0] thr
);

    localparam logic [TOT_W:0]   K_EXT   = (TOT_W + 1)'(K_WIN);
    localparam logic [BIN_W-1:0] TOP_BIN = BIN_W'(MAX_BIN);

    typedef struct packed {
        logic             busy;
        logic             issuing;
        logic [BIN_W-1:0] issue;
        logic             pend;
        logic [BIN_W-1:0] tag;
        logic [TOT_W-1:0] total;
        logic             fin;
        logic [BIN_W-1:0] thr;
    } scan_t;

    scan_t        scan_d, scan_q;
    logic [TOT_W:0] sum_w;
    logic           stop_now;

    always_comb begin
        scan_d      = scan_q;
        scan_d.fin  = 1'b0;
        scan_d.pend = 1'b0;
        sum_w       = {1'b0, scan_q.total} + {1'b0, hist_rdata};
        stop_now    = scan_q.pend && ((sum_w >= K_EXT) || (scan_q.tag == '0));

        if (go && !scan_q.busy) begin
            scan_d.busy    = 1'b1;
            scan_d.issuing = 1'b1;
            scan_d.issue   = TOP_BIN;
            scan_d.total   = '0;
        end else if (scan_q.busy) begin
            if (scan_q.issuing) begin
                scan_d.pend = 1'b1;
                scan_d.tag  = scan_q.issue;
                if (scan_q.issue == '0) begin
                    scan_d.issuing = 1'b0;
                end else begin
                    scan_d.issue = scan_q.issue - 1'b1;
                end
            end
            if (scan_q.pend) begin
                scan_d.total = sum_w[TOT_W-1:0];
                if (stop_now) begin
                    scan_d.busy    = 1'b0;
                    scan_d.issuing = 1'b0;
                    scan_d.pend    = 1'b0;
                    scan_d.fin     = 1'b1;
                    scan_d.thr     = scan_q.tag;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scan_q <= '0;
        end else begin
            scan_q <= scan_d;
        end
    end

    assign hist_ren   = scan_q.busy && scan_q.issuing;
    assign hist_raddr = scan_q.issue;
    assign fin        = scan_q.fin;
    assign thr        = scan_q.thr;

    AST_SCAN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (hist_ren && $past(hist_ren)) |-> (hist_raddr == BIN_W'($past(hist_raddr) - 1'b1))); // R2

    AST_SCAN_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        (hist_ren && !$past(hist_ren)) |-> (hist_raddr == TOP_BIN)); // R2

    AST_STOP_BIN: assert property (@(posedge clk) disable iff (!rst_n)
        fin |-> ((thr == '0) || ({1'b0, scan_q.total} >= K_EXT))); // R3

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        scan_q.pend |-> !sum_w[TOT_W]); // R5

endmodule

// File: rtl/kws_vec_emit.sv
module kws_vec_emit #(
    parameter int N_ENTRIES = 8192,
    parameter int LANES     = 64,
    parameter int MAX_BIN   = 120,
    localparam int CNT_W    = $clog2(MAX_BIN + 1),
    localparam int WORDS    = N_ENTRIES / LANES,
    localparam int WA_W     = $clog2(WORDS)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   go,
    input  logic [CNT_W-1:0]       thr_in,
    output logic                   cnt_ren,
    output logic [WA_W-1:0]        cnt_raddr,
    input  logic [LANES*CNT_W-1:0] cnt_rdata,
    output logic                   out_valid,
    output logic [WA_W-1:0]        out_idx,
    output logic [LANES-1:0]       out_bits,
    output logic                   out_last
);

    localparam logic [WA_W-1:0] LAST_WORD = WA_W'(WORDS - 1);

    typedef struct packed {
        logic             run;
        logic [WA_W-1:0]  issue;
        logic             pend;
        logic [WA_W-1:0]  ptag;
        logic [CNT_W-1:0] thr;
        logic             ov;
        logic [WA_W-1:0]  oidx;
        logic [LANES-1:0] obits;
        logic             olast;
    } emit_t;

    emit_t            emit_d, emit_q;
    logic [LANES-1:0] lane_hit;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        kws_lane_cmp #(.CNT_W(CNT_W)) u_cmp (
            .count (cnt_rdata[g*CNT_W +: CNT_W]),
            .limit (emit_q.thr),
            .hit   (lane_hit[g])
        );
    end

    always_comb begin
        emit_d       = emit_q;
        emit_d.pend  = 1'b0;
        emit_d.ov    = 1'b0;
        emit_d.olast = 1'b0;

        if (go && !emit_q.run) begin
            emit_d.run   = 1'b1;
            emit_d.issue = '0;
            emit_d.thr   = thr_in;
        end else if (emit_q.run) begin
            emit_d.pend = 1'b1;
            emit_d.ptag = emit_q.issue;
            if (emit_q.issue == LAST_WORD) begin
                emit_d.run = 1'b0;
            end else begin
                emit_d.issue = emit_q.issue + 1'b1;
            end
        end

        if (emit_q.pend) begin
            emit_d.ov    = 1'b1;
            emit_d.oidx  = emit_q.ptag;
            emit_d.obits = lane_hit;
            emit_d.olast = (emit_q.ptag == LAST_WORD);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            emit_q <= '0;
        end else begin
            emit_q <= emit_d;
        end
    end

    assign cnt_ren   = emit_q.run;
    assign cnt_raddr = emit_q.issue;
    assign out_valid = emit_q.ov;
    assign out_idx   = emit_q.oidx;
    assign out_bits  = emit_q.obits;
    assign out_last  = emit_q.olast;

    AST_WORD_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(out_valid)) |-> (out_idx == WA_W'($past(out_idx) + 1'b1))); // R7

    AST_FIRST_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !$past(out_valid)) |-> (out_idx == '0)); // R7

    AST_DONE_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |-> (out_valid && (out_idx == LAST_WORD))); // R9

endmodule

// File: rtl/kwin_select.sv
module kwin_select #(
    parameter int N_ENTRIES = 8192,
    parameter int MAX_BIN   = 120,
    parameter int K_WIN     = 512,
    parameter int LANES     = 64,
    localparam int BIN_W    = $clog2(MAX_BIN + 1),
    localparam int TOT_W    = $clog2(N_ENTRIES + 1),
    localparam int WORDS    = N_ENTRIES / LANES,
    localparam int WA_W     = $clog2(WORDS)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    output logic                   hist_ren,
    output logic [BIN_W-1:0]       hist_raddr,
    input  logic [TOT_W-1:0]       hist_rdata,
    output logic                   cnt_ren,
    output logic [WA_W-1:0]        cnt_raddr,
    input  logic [LANES*BIN_W-1:0] cnt_rdata,
    output logic [BIN_W-1:0]       thresh,
    output logic                   win_valid,
    output logic [WA_W-1:0]        win_widx,
    output logic [LANES-1:0]       win_bits,
    output logic                   done
);

    import kws_pkg::*;

    typedef struct packed {
        run_state_e       state;
        logic [BIN_W-1:0] thresh;
    } top_t;

    top_t             top_d, top_q;
    logic             scan_go;
    logic             scan_fin;
    logic [BIN_W-1:0] scan_thr;
    logic             emit_go;
    logic             emit_last;

    kws_hist_scan #(
        .MAX_BIN   (MAX_BIN),
        .K_WIN     (K_WIN),
        .N_ENTRIES (N_ENTRIES)
    ) u_scan (
        .clk        (clk),
        .rst_n      (rst_n),
        .go         (scan_go),
        .hist_ren   (hist_ren),
        .hist_raddr (hist_raddr),
        .hist_rdata (hist_rdata),
        .fin        (scan_fin),
        .thr        (scan_thr)
    );

    kws_vec_emit #(
        .N_ENTRIES (N_ENTRIES),
        .LANES     (LANES),
        .MAX_BIN   (MAX_BIN)
    ) u_emit (
        .clk       (clk),
        .rst_n     (rst_n),
        .go        (emit_go),
        .thr_in    (scan_thr),
        .cnt_ren   (cnt_ren),
        .cnt_raddr (cnt_raddr),
        .cnt_rdata (cnt_rdata),
        .out_valid (win_valid),
        .out_idx   (win_widx),
        .out_bits  (win_bits),
        .out_last  (emit_last)
    );

    always_comb begin
        top_d   = top_q;
        scan_go = 1'b0;
        emit_go = 1'b0;
        case (top_q.state)
            ST_IDLE: begin
                if (start) begin
                    scan_go     = 1'b1;
                    top_d.state = ST_SCAN;
                end
            end
            ST_SCAN: begin
                if (scan_fin) begin
                    emit_go      = 1'b1;
                    top_d.thresh = scan_thr;
                    top_d.state  = ST_EMIT;
                end
            end
            ST_EMIT: begin
                if (emit_last) begin
                    top_d.state = ST_IDLE;
                end
            end
            default: top_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            top_q <= '{state: ST_IDLE, thresh: '0};
        end else begin
            top_q <= top_d;
        end
    end

    assign thresh = top_q.thresh;
    assign done   = win_valid && emit_last;

    AST_THR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (top_q.state == ST_EMIT) |=> $stable(thresh)); // R8

    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (start && (top_q.state == ST_EMIT) && !emit_last) |=> (top_q.state == ST_EMIT)); // R10

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R9

endmodule

// File: tb/sim_kwin_select.sv
`timescale 1ns/1ps
module sim_kwin_select;

    localparam int N     = 8192;
    localparam int MAXB  = 120;
    localparam int LN    = 64;
    localparam int NW    = N / LN;
    localparam int NPAT  = 8;

    // columns: pattern mode, histogram forced to zero, expected threshold, expected winners
    localparam int TBL [NPAT][4] = '{
        '{0, 0, 113, 469},
        '{1, 0,   0,   0},
        '{2, 0, 120,   0},
        '{3, 0, 100,   0},
        '{4, 0,   0, 511},
        '{0, 1,   0, 8124},
        '{6, 0,  60, 300},
        '{7, 0, 109, 511}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          hist_ren;
    logic [6:0]    hist_raddr;
    logic [13:0]   hist_rdata = '0;
    logic          cnt_ren;
    logic [6:0]    cnt_raddr;
    logic [447:0]  cnt_rdata = '0;
    logic [6:0]    thresh;
    logic          win_valid;
    logic [6:0]    win_widx;
    logic [63:0]   win_bits;
    logic          done;

    logic [13:0]   hist_mem [0:127];
    logic [6:0]    cnt_mem  [0:N-1];

    int checks = 0;
    int errors = 0;
    int prev_thr = 0;

    always #4 clk = ~clk;

    kwin_select u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .hist_ren   (hist_ren),
        .hist_raddr (hist_raddr),
        .hist_rdata (hist_rdata),
        .cnt_ren    (cnt_ren),
        .cnt_raddr  (cnt_raddr),
        .cnt_rdata  (cnt_rdata),
        .thresh     (thresh),
        .win_valid  (win_valid),
        .win_widx   (win_widx),
        .win_bits   (win_bits),
        .done       (done)
    );

    always_ff @(posedge clk) begin
        if (hist_ren) hist_rdata <= hist_mem[hist_raddr];
        if (cnt_ren) begin
            for (int l = 0; l < LN; l++) begin
                cnt_rdata[l*7 +: 7] <= cnt_mem[int'(cnt_raddr) * LN + l];
            end
        end
    end

    function automatic int cnt_of(int mode, int i);
        case (mode)
            0: return i % 121;
            1: return 0;
            2: return 120;
            3: return (i < 512) ? 100 : 5;
            4: return (i < 511) ? 100 : 0;
            6: return (i < 300) ? 120 : 60;
            7: return (i < 511) ? 110 : ((i < 513) ? 109 : 3);
            default: return 0;
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic load(input int mode, input int hzero);
        for (int b = 0; b < 128; b++) hist_mem[b] = '0;
        for (int i = 0; i < N; i++) begin
            cnt_mem[i] = 7'(cnt_of(mode, i));
            if (hzero == 0) hist_mem[cnt_mem[i]] = hist_mem[cnt_mem[i]] + 14'd1;
        end
    endtask

    // Runs one pass; poke sends a second start while the vector is coming out.
    task automatic run_pass(input int exp_thr, input int exp_wins, input bit poke);
        int words = 0;
        int wins = 0;
        int bad_words = 0;
        int bad_idx = 0;
        int gaps = 0;
        int last_vcyc = -1;
        int first_addr = -1;
        int prev_addr = -1;
        int step_bad = 0;
        int thr_scan_bad = 0;
        int thr_emit_bad = 0;
        bit got_done = 0;
        int done_word = -1;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        for (int cyc = 0; cyc < 3000; cyc++) begin
            if (poke) start = (words == 5);
            if (hist_ren) begin
                if (first_addr < 0) first_addr = int'(hist_raddr);
                else if (int'(hist_raddr) != prev_addr - 1) step_bad++;
                prev_addr = int'(hist_raddr);
                if (int'(thresh) != prev_thr) thr_scan_bad++;
            end
            if (win_valid) begin
                if (int'(win_widx) != words) bad_idx++;
                if (last_vcyc >= 0 && cyc != last_vcyc + 1) gaps++;
                last_vcyc = cyc;
                if (int'(thresh) != exp_thr) thr_emit_bad++;
                for (int l = 0; l < LN; l++) begin
                    if (win_bits[l] != (int'(cnt_mem[int'(win_widx) * LN + l]) > exp_thr)) begin
                        bad_words++;
                        break;
                    end
                end
                wins += $countones(win_bits);
                words++;
            end
            if (done) begin
                got_done = 1;
                done_word = win_valid ? int'(win_widx) : -1;
                @(negedge clk);
                start = 1'b0;
                check(!done, "R9 done single cycle", int'(done), 0);
                break;
            end
            @(negedge clk);
        end
        start = 1'b0;
        check(first_addr == MAXB, "R2 first bin", first_addr, MAXB);
        check(step_bad == 0, "R2 downward step", step_bad, 0);
        check(int'(thresh) == exp_thr, "R3 R4 threshold", int'(thresh), exp_thr);
        check(thr_scan_bad == 0, "R8 threshold held during scan", thr_scan_bad, 0);
        check(thr_emit_bad == 0, "R8 threshold held during output", thr_emit_bad, 0);
        check(bad_words == 0, "R6 winner bits", bad_words, 0);
        check(wins == exp_wins, "R6 winner total", wins, exp_wins);
        check(words == NW && bad_idx == 0 && gaps == 0, "R7 word stream", words, NW);
        check(got_done && done_word == NW - 1, "R9 done with last word", done_word, NW - 1);
        prev_thr = exp_thr;
    endtask

    initial begin
        for (int c = 0; c < 150000; c++) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        load(0, 0);
        repeat (3) @(negedge clk);
        check(thresh == '0 && !win_valid && !done && !hist_ren && !cnt_ren,
              "R1 reset state", int'(thresh), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!win_valid && !done && !hist_ren && !cnt_ren, "R1 idle after reset",
              int'(win_valid), 0);

        // table of patterns; R3 R4 R5 exercised by thresholds and both stop causes
        for (int p = 0; p < NPAT; p++) begin
            load(TBL[p][0], TBL[p][1]);
            repeat (2) @(negedge clk);
            run_pass(TBL[p][2], TBL[p][3], 1'b0);
        end

        // R10: second start while the vector is coming out
        load(0, 0);
        repeat (2) @(negedge clk);
        run_pass(113, 469, 1'b1);
        begin
            int stray = 0;
            for (int c = 0; c < 400; c++) begin
                @(negedge clk);
                if (win_valid || hist_ren || cnt_ren) stray++;
            end
            check(stray == 0, "R10 start ignored while busy", stray, 0);
            check(int'(thresh) == 113, "R10 threshold unchanged", int'(thresh), 113);
        end

        // R8: a fresh run keeps the old threshold until its scan ends
        load(2, 0);
        repeat (2) @(negedge clk);
        run_pass(120, 0, 1'b0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule